// File: doc/BRIEF.md
# Ternary Lattice Function Evaluator

This block evaluates a three-valued function that has been mapped onto a regular three-dimensional lattice of shared three-way selector nodes. Every level of the lattice is steered by one ternary control. A control of 0 moves the evaluation path one step along x, a 1 moves it along y, and a 2 moves it along z. Nodes sit on cube corners, and paths that take the same steps in a different order end on the same node. The leaf that is reached therefore depends only on how many controls of each value were seen, and not on the order in which they came.

Each level takes its control from a configured input trit, with an optional shift of +1 or +2 modulo 3. This lets one input be used on several levels, which is how a function that is not symmetric is made to fit the lattice. Software loads the leaf trits through a write port that is addressed by the count of 1-steps and the count of 2-steps. It programs each level's input index and shift, then pulses `start` with the input trits and the number of active levels. One cycle later the result trit appears with a valid strobe, or an error strobe if the request is illegal.

Top module: `ternary_lattice_eval`

## Requirements
- R1: After reset the outputs `out_valid`, `out_err` and `out_trit` are all 0, every leaf holds 0, and every level is configured with input index 0 and shift 0.
- R2: Trits are encoded on 2 bits as 00=0, 01=1, 10=2, and 11 is illegal. A leaf write stores `leaf_val` at the leaf (`leaf_n1`, `leaf_n2`). A write with value 11, or with `leaf_n1 + leaf_n2` greater than MAX_LVL, has no effect.
- R3: For each active level l, the effective control is (input trit `x_in[2*sel+:2]` + shift) mod 3. The result is the leaf at (n1, n2), where n1 and n2 are the numbers of active levels whose control is 1 and 2.
- R4: Two requests whose active controls contain the same number of 0s, 1s and 2s, in any order, return the same result.
- R5: Only levels 0 to `n_levels`-1 are active. With `n_levels` equal to 0 the result is the leaf (0,0), whatever the inputs are.
- R6: The cycle after a `start` edge, exactly one of `out_valid` and `out_err` is high for one cycle. With no `start`, both are low and `out_trit` holds its value. A `start` uses the leaf and configuration contents from before that same edge.
- R7: A request is illegal, and raises `out_err` without changing `out_trit`, in any of these cases: an active level selects an input trit of 11, an active level has shift 11, an active level has an index of NUM_IN or more, or `n_levels` is greater than MAX_LVL.
- R8: A configuration write sets the input index and shift of level `cfg_lvl`. A write with `cfg_lvl` of MAX_LVL or more has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| leaf_we | input | 1 | Leaf write enable |
| leaf_n1 | input | 3 | Leaf address: count of 1-steps |
| leaf_n2 | input | 3 | Leaf address: count of 2-steps |
| leaf_val | input | 2 | Leaf trit to store |
| cfg_we | input | 1 | Level configuration write enable |
| cfg_lvl | input | 3 | Level to configure |
| cfg_sel | input | 3 | Input index for that level |
| cfg_shift | input | 2 | Shift modulo 3 for that level |
| start | input | 1 | Evaluate request |
| n_levels | input | 3 | Number of active levels |
| x_in | input | 8 | Input trits, 2 bits each, trit k at bits 2k+1:2k |
| out_valid | output | 1 | Result strobe |
| out_err | output | 1 | Illegal-request strobe |
| out_trit | output | 2 | Result trit |

## Verification
The bench targets the order independence of the lattice: permutations of the same control values must reach one leaf. A design that wired the levels as a tree instead would return different trits for them. It repeats one input over several levels with shifts 0, 1 and 2, so that every control value appears whatever the input is, which exposes a shift that is dropped or applied the wrong way. It checks zero active levels, a full lattice, writes of 11 and writes to leaf addresses or levels that are out of range, and each illegal request. A design that checked inactive levels would raise false errors, and one that updated the result on an error would corrupt `out_trit`. Random requests against a reference model cover the rest.

// File: rtl/ternary_lattice_eval.sv
module ternary_lattice_eval #(
  parameter int NUM_IN  = 4,
  parameter int MAX_LVL = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  leaf_we,
  input  logic [2:0]            leaf_n1,
  input  logic [2:0]            leaf_n2,
  input  logic [1:0]            leaf_val,
  input  logic                  cfg_we,
  input  logic [2:0]            cfg_lvl,
  input  logic [2:0]            cfg_sel,
  input  logic [1:0]            cfg_shift,
  input  logic                  start,
  input  logic [2:0]            n_levels,
  input  logic [2*NUM_IN-1:0]   x_in,
  output logic                  out_valid,
  output logic                  out_err,
  output logic [1:0]            out_trit
);
  localparam int CW = 3;

  logic [1:0] leaf_q [0:MAX_LVL][0:MAX_LVL];
  logic [2:0] sel_q  [MAX_LVL];
  logic [1:0] sh_q   [MAX_LVL];

  logic [CW-1:0] cnt1, cnt2;
  logic          bad;
  logic [1:0]    t, v;
  logic [1:0]    leaf_rd;

  function automatic logic [1:0] add3(input logic [1:0] a, input logic [1:0] b);
    logic [2:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s >= 3'd3) ? 2'(s - 3'd3) : s[1:0];
  endfunction

  wire [3:0] leaf_sum = {1'b0, leaf_n1} + {1'b0, leaf_n2};
  wire leaf_ok = leaf_we && leaf_val != 2'b11 && leaf_sum <= 4'(MAX_LVL);
  wire cfg_ok  = cfg_we && int'(cfg_lvl) < MAX_LVL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= MAX_LVL; i++)
        for (int j = 0; j <= MAX_LVL; j++)
          leaf_q[i][j] <= 2'b00;
      for (int l = 0; l < MAX_LVL; l++) begin
        sel_q[l] <= 3'd0;
        sh_q[l]  <= 2'd0;
      end
    end else begin
      if (leaf_ok) leaf_q[leaf_n1][leaf_n2] <= leaf_val;
      if (cfg_ok) begin
        sel_q[cfg_lvl] <= cfg_sel;
        sh_q[cfg_lvl]  <= cfg_shift;
      end
    end
  end

  always_comb begin
    cnt1 = '0;
    cnt2 = '0;
    bad  = int'(n_levels) > MAX_LVL;
    t    = 2'b00;
    v    = 2'b00;
    for (int l = 0; l < MAX_LVL; l++) begin
      if (l < int'(n_levels)) begin
        if (int'(sel_q[l]) >= NUM_IN || sh_q[l] == 2'b11) begin
          bad = 1'b1;
        end else begin
          t = 2'b00;
          for (int k = 0; k < NUM_IN; k++)
            if (int'(sel_q[l]) == k) t = x_in[2*k +: 2];
          if (t == 2'b11) begin
            bad = 1'b1;
          end else begin
            v = add3(t, sh_q[l]);
            if (v == 2'd1) cnt1 = cnt1 + CW'(1);
            if (v == 2'd2) cnt2 = cnt2 + CW'(1);
          end
        end
      end
    end
  end

  assign leaf_rd = leaf_q[cnt1][cnt2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_trit  <= 2'b00;
    end else begin
      out_valid <= start && !bad;
      out_err   <= start && bad;
      if (start && !bad) out_trit <= leaf_rd;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_err));                                              // R6
  AST_STROBE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || out_err) |-> $past(start));                               // R6
  AST_START_GIVES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (out_valid || out_err));                                      // R6
  AST_TRIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_trit));                                      // R7
  AST_TRIT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_trit != 2'b11);                                                     // R2
endmodule

// File: tb/ternary_lattice_eval_test.sv
`timescale 1ns/1ps
module ternary_lattice_eval_test;
  localparam int NI = 4;
  localparam int ML = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic leaf_we = 1'b0;
  logic [2:0] leaf_n1 = '0, leaf_n2 = '0;
  logic [1:0] leaf_val = '0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_lvl = '0, cfg_sel = '0;
  logic [1:0] cfg_shift = '0;
  logic start = 1'b0;
  logic [2:0] n_levels = '0;
  logic [2*NI-1:0] x_in = '0;
  logic out_valid, out_err;
  logic [1:0] out_trit;

  int checks = 0;
  int errors = 0;

  logic [1:0] m_leaf [0:ML][0:ML];
  int m_sel [ML];
  int m_sh  [ML];
  logic [1:0] m_trit = 2'b00;

  ternary_lattice_eval #(.NUM_IN(NI), .MAX_LVL(ML)) uut (
    .clk(clk), .rst_n(rst_n),
    .leaf_we(leaf_we), .leaf_n1(leaf_n1), .leaf_n2(leaf_n2), .leaf_val(leaf_val),
    .cfg_we(cfg_we), .cfg_lvl(cfg_lvl), .cfg_sel(cfg_sel), .cfg_shift(cfg_shift),
    .start(start), .n_levels(n_levels), .x_in(x_in),
    .out_valid(out_valid), .out_err(out_err), .out_trit(out_trit));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_leaf(input int n1, input int n2, input logic [1:0] val);
    @(negedge clk);
    leaf_we = 1'b1; leaf_n1 = 3'(n1); leaf_n2 = 3'(n2); leaf_val = val;
    @(negedge clk);
    leaf_we = 1'b0;
    if (val != 2'b11 && n1 + n2 <= ML) m_leaf[n1][n2] = val;
  endtask

  task automatic wr_cfg(input int lvl, input int sel, input int sh);
    @(negedge clk);
    cfg_we = 1'b1; cfg_lvl = 3'(lvl); cfg_sel = 3'(sel); cfg_shift = 2'(sh);
    @(negedge clk);
    cfg_we = 1'b0;
    if (lvl < ML) begin m_sel[lvl] = sel; m_sh[lvl] = sh; end
  endtask

  function automatic logic [2:0] expect_eval(input logic [2*NI-1:0] x, input int nl);
    int c1 = 0, c2 = 0;
    bit bad = (nl > ML);
    for (int l = 0; l < ML; l++) begin
      if (l < nl) begin
        if (m_sel[l] >= NI || m_sh[l] == 3) bad = 1;
        else begin
          int t = int'(x[2*m_sel[l] +: 2]);
          if (t == 3) bad = 1;
          else begin
            int v = (t + m_sh[l]) % 3;
            if (v == 1) c1++;
            if (v == 2) c2++;
          end
        end
      end
    end
    return bad ? 3'b100 : {1'b0, m_leaf[c1][c2]};
  endfunction

  task automatic run(input logic [2*NI-1:0] x, input int nl, input string req);
    logic [2:0] e;
    e = expect_eval(x, nl);
    @(negedge clk);
    start = 1'b1; x_in = x; n_levels = 3'(nl);
    @(negedge clk);
    start = 1'b0;
    if (e[2]) begin
      chk(out_err == 1'b1 && out_valid == 1'b0, req, {out_err, out_valid}, 2);
      chk(out_trit == m_trit, req, out_trit, m_trit);
    end else begin
      m_trit = e[1:0];
      chk(out_valid == 1'b1 && out_err == 1'b0, req, {out_err, out_valid}, 1);
      chk(out_trit == m_trit, req, out_trit, m_trit);
    end
    @(negedge clk);
    chk(out_valid == 1'b0 && out_err == 1'b0 && out_trit == m_trit, "R6 idle",
        {out_valid, out_err, out_trit}, m_trit);
  endtask

  function automatic logic [2*NI-1:0] pack(input int a, input int b, input int c, input int d);
    return {2'(d), 2'(c), 2'(b), 2'(a)};
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i <= ML; i++) for (int j = 0; j <= ML; j++) m_leaf[i][j] = 2'b00;
    for (int l = 0; l < ML; l++) begin m_sel[l] = 0; m_sh[l] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 0 && out_err == 0 && out_trit == 0, "R1 outputs", {out_valid, out_err, out_trit}, 0);
    run(pack(1, 0, 0, 0), ML, "R1 leaves/cfg zero");

    // R2: fill leaves with distinct pattern, then illegal writes ignored
    for (int i = 0; i <= ML; i++)
      for (int j = 0; i + j <= ML; j++) wr_leaf(i, j, 2'((i + 2 * j + 1) % 3));
    wr_leaf(0, 0, 2'b10);
    wr_leaf(0, 0, 2'b11);
    run(pack(0, 0, 0, 0), 0, "R2 val 11 ignored");
    chk(out_trit == 2'b10, "R2 stored", out_trit, 2);
    wr_leaf(4, 4, 2'b01);
    run(pack(0, 0, 0, 0), 0, "R2 addr out of range");

    // R5: zero levels ignores inputs, even illegal ones
    run(pack(3, 3, 3, 3), 0, "R5 zero levels");

    // R3 directed: levels 0..2 on inputs 0..2
    wr_cfg(0, 0, 0); wr_cfg(1, 1, 0); wr_cfg(2, 2, 0);
    wr_leaf(1, 1, 2'b01);
    run(pack(0, 1, 2, 0), 3, "R3 one of each");
    chk(out_trit == 2'b01, "R3 leaf(1,1)", out_trit, 1);
    // R4 permutations of (0,0,2) share leaf (0,1)
    wr_leaf(0, 1, 2'b10);
    run(pack(2, 0, 0, 0), 3, "R4 perm a");
    run(pack(0, 2, 0, 0), 3, "R4 perm b");
    run(pack(0, 0, 2, 3), 3, "R4 perm c, R5 unused input 11");
    chk(out_trit == 2'b10, "R4 shared leaf", out_trit, 2);

    // R3 repetition with shifts: one input on three levels covers every value
    wr_cfg(0, 3, 0); wr_cfg(1, 3, 1); wr_cfg(2, 3, 2);
    for (int k = 0; k < 3; k++) begin
      run(pack(0, 0, 0, k), 3, "R3 repeated var");
      chk(out_trit == 2'b01, "R3 shift rotate", out_trit, 1);
    end

    // R7 errors
    run(pack(0, 0, 0, 3), 3, "R7 input 11");
    run(pack(0, 0, 0, 1), 7, "R7 too many levels");
    wr_cfg(1, 5, 0);
    run(pack(0, 0, 0, 1), 3, "R7 index out of range");
    wr_cfg(1, 3, 3);
    run(pack(0, 0, 0, 1), 3, "R7 shift 11");
    wr_cfg(1, 3, 1);
    // R8 out-of-range level write ignored
    wr_cfg(6, 5, 3);
    wr_cfg(7, 5, 3);
    run(pack(1, 2, 0, 1), ML, "R8 level write ignored");

    // full lattice with random leaves and configs
    for (int it = 0; it < 400; it++) begin
      if ($urandom % 4 == 0)
        wr_leaf($urandom % 7, $urandom % 7, 2'($urandom % 4));
      if ($urandom % 3 == 0) begin
        int s = ($urandom % 12 == 0) ? 4 + $urandom % 4 : $urandom % NI;
        int h = ($urandom % 15 == 0) ? 3 : $urandom % 3;
        wr_cfg($urandom % 8, s, h);
      end
      begin
        logic [2*NI-1:0] x;
        for (int k = 0; k < NI; k++)
          x[2*k +: 2] = ($urandom % 25 == 0) ? 2'b11 : 2'($urandom % 3);
        run(x, ($urandom % 10 == 0) ? 7 : $urandom % 7, "R3 random");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule